// File: doc/BRIEF.md
# Centre-Aligned Five-State Switching Sequencer

This block turns one switching period's worth of dwell counts into a timed stream of switching-state codes, one code per clock. Four counts give the on-times of the four active states, formed from two adjacent output vectors (A and B) each built from one of two input phases (P and Q). A fifth count gives the on-time of the null state, where every output sits on a single input phase. Each interval is cut into two halves, and the halves are laid out mirror-wise about the centre of the period. The result is a centre-aligned pattern that starts and ends on the null state.

A flag, updated every 30 degrees by the angle logic upstream, tells the sequencer which input phase currently carries the higher input line voltage. The states built from that phase go to the middle of each half period. The states built from the other phase go next to the null state at the edges. A one-clock period-start pulse latches the counts and the flag and begins a new period, even if the previous one is still running. The code stream feeds a gate distributor, which lies outside this block, as does the computation of the dwell counts.

Top module: `svmSeq`

## Requirements
- R1: The state code is 0 (null) after reset and in every cycle where no period is running. The codes are: 0 null, 1 vector A on phase P, 2 vector A on phase Q, 3 vector B on phase P, 4 vector B on phase Q. No other value is ever output.
- R2: Dwell counts and the high-phase flag are captured only on the period-start clock edge. Changes on those inputs during a running period do not alter the code stream of that period.
- R3: The first half of a period runs null, A-low, B-low, B-high, A-high. The second half runs the same five in reverse order, so the pattern is mirrored about its centre.
- R4: With the high-phase flag at 1, phase Q is high: codes 2 and 4 are the middle (high) states and codes 1 and 3 the edge (low) states. With the flag at 0 the roles are swapped.
- R5: An interval of d clocks gets floor(d/2) clocks in the first half and d minus floor(d/2) clocks in the second half.
- R6: An interval with a dwell count of zero does not appear in the stream. A period whose five counts are all zero outputs only code 0.
- R7: Over one period, each active code is output for exactly its dwell count in clocks, and the null code for its dwell count. The period lasts the sum of the five counts.
- R8: Timing: in the cycle after the period-start edge the code is 0. Tick j of the period (j from 0) appears after the (j+1)-th edge following the start. The code returns to 0 in the cycle after the last tick.
- R9: A period start during a running period abandons the old sequence and begins the new one with the R8 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| periodStart | input | 1 | One-clock pulse beginning a switching period |
| qHigher | input | 1 | 1 when phase Q gives the higher input line voltage |
| dwellNull | input | CNT_W | Null state on-time in clocks |
| dwellAP | input | CNT_W | Vector A on phase P on-time |
| dwellAQ | input | CNT_W | Vector A on phase Q on-time |
| dwellBP | input | CNT_W | Vector B on phase P on-time |
| dwellBQ | input | CNT_W | Vector B on phase Q on-time |
| stateCode | output | 3 | Registered switching-state code |

## Verification
The assertions check, on every cycle, the properties that follow from local timing. The code never leaves the five legal values. The cycle after a period start is null, and so is every cycle without a running period. A period stops one tick after its last tick unless a restart arrives. The order of the states, the floor/ceiling split of odd counts, the skipping of empty intervals, the swap of inner and outer roles with the high-phase flag, the exact per-code on-times and the effect of a mid-period restart all depend on whole periods. Only the bench's directed scenarios show these, by comparing each cycle with a sequence built from the requirements.

// File: rtl/svmSeqPkg.sv
package svmSeqPkg;

  typedef enum logic [2:0] {
    S_NULL = 3'd0,
    S_A_P  = 3'd1,
    S_A_Q  = 3'd2,
    S_B_P  = 3'd3,
    S_B_Q  = 3'd4
  } stateCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture inputs, clear tick, output null
    logic emit;   // output code of current tick, advance tick
  } seqStrobe_t;

  localparam int NUM_ELEM  = 5;              // distinct states per period
  localparam int NUM_SLOTS = 2 * NUM_ELEM;   // halved and mirrored

endpackage

// File: rtl/svmSeqCtrl.sv
module svmSeqCtrl
  import svmSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodStart,
  input  logic       lastTick,
  output seqStrobe_t stb
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    stb.load = periodStart;
    stb.emit = (state == ST_RUN) && !periodStart;
  end

  always_comb begin
    stateNext = state;
    if (periodStart) begin
      stateNext = ST_RUN;
    end else if (state == ST_RUN && lastTick) begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/svmSeqPath.sv
module svmSeqPath
  import svmSeqPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic             qHigher,
  input  logic [CNT_W-1:0] dwellNull,
  input  logic [CNT_W-1:0] dwellAP,
  input  logic [CNT_W-1:0] dwellAQ,
  input  logic [CNT_W-1:0] dwellBP,
  input  logic [CNT_W-1:0] dwellBQ,
  output logic             lastTick,
  output logic [2:0]       stateCode
);

  localparam int SUM_W = CNT_W + 3;   // room for five full counts

  logic [CNT_W-1:0] latDwell [NUM_ELEM];
  logic             latQHigh;
  logic [SUM_W-1:0] tick;
  stateCode_t       codeReg;

  // element list of one half period: null, A-low, B-low, B-high, A-high
  logic [CNT_W-1:0] elemDwell [NUM_ELEM];
  stateCode_t       elemCode  [NUM_ELEM];

  always_comb begin
    elemDwell[0] = latDwell[0];
    elemCode[0]  = S_NULL;
    elemDwell[1] = latQHigh ? latDwell[1] : latDwell[2];
    elemCode[1]  = latQHigh ? S_A_P : S_A_Q;
    elemDwell[2] = latQHigh ? latDwell[3] : latDwell[4];
    elemCode[2]  = latQHigh ? S_B_P : S_B_Q;
    elemDwell[3] = latQHigh ? latDwell[4] : latDwell[3];
    elemCode[3]  = latQHigh ? S_B_Q : S_B_P;
    elemDwell[4] = latQHigh ? latDwell[2] : latDwell[1];
    elemCode[4]  = latQHigh ? S_A_Q : S_A_P;
  end

  logic [SUM_W-1:0] slotLen  [NUM_SLOTS];
  stateCode_t       slotCode [NUM_SLOTS];
  logic [SUM_W-1:0] slotEnd  [NUM_SLOTS];

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s < NUM_ELEM) begin : g_first
        // first half: floor of the count
        assign slotLen[s]  = SUM_W'(elemDwell[s] >> 1);
        assign slotCode[s] = elemCode[s];
      end else begin : g_second
        // mirrored second half: remainder, so the extra tick lands here
        assign slotLen[s]  = SUM_W'(elemDwell[NUM_SLOTS-1-s])
                           - SUM_W'(elemDwell[NUM_SLOTS-1-s] >> 1);
        assign slotCode[s] = elemCode[NUM_SLOTS-1-s];
      end
    end
  endgenerate

  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      acc        = acc + slotLen[i];
      slotEnd[i] = acc;
    end
  end

  // first slot whose end lies beyond the current tick
  stateCode_t pick;
  always_comb begin
    pick = S_NULL;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (tick < slotEnd[i]) begin
        pick = slotCode[i];
      end
    end
  end

  assign lastTick = ({1'b0, tick} + {{SUM_W{1'b0}}, 1'b1})
                    >= {1'b0, slotEnd[NUM_SLOTS-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ELEM; i++) begin
        latDwell[i] <= '0;
      end
      latQHigh <= 1'b0;
      tick     <= '0;
      codeReg  <= S_NULL;
    end else if (stb.load) begin
      latDwell[0] <= dwellNull;
      latDwell[1] <= dwellAP;
      latDwell[2] <= dwellAQ;
      latDwell[3] <= dwellBP;
      latDwell[4] <= dwellBQ;
      latQHigh    <= qHigher;
      tick        <= '0;
      codeReg     <= S_NULL;
    end else if (stb.emit) begin
      codeReg <= pick;
      tick    <= tick + 1'b1;
    end else begin
      codeReg <= S_NULL;
    end
  end

  assign stateCode = codeReg;

endmodule

// File: rtl/svmSeq.sv
module svmSeq
  import svmSeqPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  input  logic             qHigher,
  input  logic [CNT_W-1:0] dwellNull,
  input  logic [CNT_W-1:0] dwellAP,
  input  logic [CNT_W-1:0] dwellAQ,
  input  logic [CNT_W-1:0] dwellBP,
  input  logic [CNT_W-1:0] dwellBQ,
  output logic [2:0]       stateCode
);

  seqStrobe_t stb;
  logic       lastTick;

  svmSeqCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .periodStart (periodStart),
    .lastTick    (lastTick),
    .stb         (stb)
  );

  svmSeqPath #(.CNT_W(CNT_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .qHigher   (qHigher),
    .dwellNull (dwellNull),
    .dwellAP   (dwellAP),
    .dwellAQ   (dwellAQ),
    .dwellBP   (dwellBP),
    .dwellBQ   (dwellBQ),
    .lastTick  (lastTick),
    .stateCode (stateCode)
  );

endmodule

// File: rtl/svmSeqChecker.sv
module svmSeqChecker
  import svmSeqPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       periodStart,
  input seqStrobe_t stb,
  input logic       lastTick,
  input logic [2:0] stateCode
);

  // R1: only the five defined codes
  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd4);

  // R1: no running period means null in the next cycle
  a_r1_idle_null: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.emit && !stb.load) |=> stateCode == 3'd0);

  // R8: the cycle after a period start is null
  a_r8_start_null: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> stateCode == 3'd0);

  // R8: a period stops after its last tick unless restarted
  a_r8_period_end: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && lastTick && !periodStart) |=> !stb.emit);

  // R9: a start always leaves the sequencer running
  a_r9_restart_runs: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> (stb.emit || periodStart));

endmodule

bind svmSeq svmSeqChecker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .periodStart (periodStart),
  .stb         (stb),
  .lastTick    (lastTick),
  .stateCode   (stateCode)
);

// File: tb/tb_svmSeq.sv
module tb_svmSeq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             periodStart = 1'b0;
  logic             qHigher = 1'b0;
  logic [CNT_W-1:0] dwellNull = '0;
  logic [CNT_W-1:0] dwellAP = '0;
  logic [CNT_W-1:0] dwellAQ = '0;
  logic [CNT_W-1:0] dwellBP = '0;
  logic [CNT_W-1:0] dwellBQ = '0;
  logic [2:0]       stateCode;

  int checks = 0;
  int fails  = 0;

  logic [2:0] expSeq [0:1023];
  int         expLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  svmSeq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .qHigher(qHigher),
    .dwellNull(dwellNull), .dwellAP(dwellAP), .dwellAQ(dwellAQ),
    .dwellBP(dwellBP), .dwellBQ(dwellBQ), .stateCode(stateCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected stream from R3, R4, R5, R6
  task automatic buildExp(input int dN, input int dAP, input int dAQ,
                          input int dBP, input int dBQ, input logic qh);
    int d [5];
    int c [5];
    d[0] = dN;               c[0] = 0;
    d[1] = qh ? dAP : dAQ;   c[1] = qh ? 1 : 2;   // A low
    d[2] = qh ? dBP : dBQ;   c[2] = qh ? 3 : 4;   // B low
    d[3] = qh ? dBQ : dBP;   c[3] = qh ? 4 : 3;   // B high
    d[4] = qh ? dAQ : dAP;   c[4] = qh ? 2 : 1;   // A high
    expLen = 0;
    for (int s = 0; s < 10; s++) begin
      int e;
      int len;
      e   = (s < 5) ? s : 9 - s;
      len = (s < 5) ? d[e] / 2 : d[e] - d[e] / 2;
      for (int k = 0; k < len; k++) begin
        expSeq[expLen] = 3'(c[e]);
        expLen++;
      end
    end
  endtask

  // One period; abortAfter >= 0 stops early (a restart follows)
  task automatic runPeriod(input string tag, input int dN, input int dAP,
                           input int dAQ, input int dBP, input int dBQ,
                           input logic qh, input int abortAfter);
    int seqBad;
    int badAt;
    int badAct;
    int cnt [5];
    int n;
    buildExp(dN, dAP, dAQ, dBP, dBQ, qh);
    @(negedge clk);
    dwellNull = CNT_W'(dN); dwellAP = CNT_W'(dAP); dwellAQ = CNT_W'(dAQ);
    dwellBP = CNT_W'(dBP); dwellBQ = CNT_W'(dBQ); qHigher = qh;
    periodStart = 1'b1;
    @(negedge clk);
    periodStart = 1'b0;
    // R2: scramble inputs while the period runs
    dwellNull = 12'd7; dwellAP = 12'd3; dwellAQ = 12'd9;
    dwellBP = 12'd1; dwellBQ = 12'd5; qHigher = ~qh;
    check({tag, " R8 null after start"}, int'(stateCode), 0);
    n = (abortAfter >= 0 && abortAfter < expLen) ? abortAfter : expLen;
    seqBad = 0; badAt = 0; badAct = 0;
    for (int i = 0; i < 5; i++) cnt[i] = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (stateCode <= 3'd4) cnt[stateCode]++;
      if (stateCode != expSeq[j] && !seqBad) begin
        seqBad = 1; badAt = j; badAct = int'(stateCode);
      end
    end
    checks++;
    if (seqBad) begin
      fails++;
      $display("FAIL %s R3 R4 R5 R2 tick %0d actual=%0d expected=%0d",
               tag, badAt, badAct, expSeq[badAt]);
    end
    if (abortAfter < 0) begin
      check({tag, " R7 null on-time"},  cnt[0], dN);
      check({tag, " R7 A-P on-time"},   cnt[1], dAP);
      check({tag, " R7 A-Q on-time"},   cnt[2], dAQ);
      check({tag, " R7 B-P on-time"},   cnt[3], dBP);
      check({tag, " R7 B-Q on-time"},   cnt[4], dBQ);
      @(negedge clk);
      check({tag, " R8 null after end"}, int'(stateCode), 0);
    end
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 reset null", int'(stateCode), 0);
    end
  endtask

  task automatic testEvenLowP();
    runPeriod("even qh0", 4, 6, 2, 8, 4, 1'b0, -1);
  endtask

  task automatic testEvenLowQ();
    runPeriod("R4 even qh1", 4, 6, 2, 8, 4, 1'b1, -1);
  endtask

  task automatic testOdd();
    runPeriod("R5 odd", 5, 3, 7, 1, 9, 1'b0, -1);
    runPeriod("R5 odd qh1", 3, 11, 5, 3, 1, 1'b1, -1);
  endtask

  task automatic testEmpty();
    runPeriod("R6 empty slots", 0, 5, 0, 6, 0, 1'b1, -1);
  endtask

  task automatic testAllZero();
    @(negedge clk);
    dwellNull = '0; dwellAP = '0; dwellAQ = '0; dwellBP = '0; dwellBQ = '0;
    periodStart = 1'b1;
    @(negedge clk);
    periodStart = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R6 all-zero period null", int'(stateCode), 0);
      @(negedge clk);
    end
  endtask

  task automatic testRestart();
    runPeriod("R9 first", 6, 10, 10, 10, 10, 1'b0, 9);
    runPeriod("R9 restarted", 2, 4, 3, 5, 6, 1'b1, -1);
  endtask

  task automatic testIdleGap();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 idle between periods", int'(stateCode), 0);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEvenLowP();
    testEvenLowQ();
    testOdd();
    testEmpty();
    testAllZero();
    testRestart();
    testIdleGap();
    finishRun();
  end

endmodule